// File: doc/BRIEF.md
# Pulse Width and Period Meter

This block times an interval on a single digital input with one up counter. In width mode the counter runs while the input sits at its active level. In period mode the counter runs from one activating edge of the input to the next activating edge. A polarity field picks which level counts as active, and the same field can switch the measurement off altogether.

Counts come from one of two sources. The first is a synchronous tick input, normally the output of a prescaler outside the block. The second is the edges of an asynchronous external clock, rising or falling as selected. A trigger pulse clears the counter and arms one measurement. When the measurement finishes, the count is copied into a readback register and a done flag is set. An interrupt pulse can also be raised. If the count passes its maximum, it stays at all ones and an overflow flag is set.

Top module: `interval_meter`

## Requirements
- R1: `in_pol` selects the active level of `meas_in`: 2'b10 means high is active, 2'b01 means low is active. With 2'b00 or 2'b11 no measurement starts, `done` stays 0 and `readback` keeps its value.
- R2: With `mode_period`=0, the result is the number of count enables seen while `meas_in` is at its active level. With a tick on every clock, this equals the pulse length in clock cycles.
- R3: With `mode_period`=1, the result is the number of count enables from one inactive-to-active transition of `meas_in` to the next one.
- R4: A `trigger` high at a clock edge clears the counter, `done` and `overflow`, and arms a new measurement. This also abandons any measurement already in progress.
- R5: If the input is already at its active level when the trigger arrives, that interval is ignored. Counting waits for the next inactive-to-active transition.
- R6: `clk_sel` picks the count enable: 2'b00 or 2'b11 uses `tick`, 2'b01 uses rising edges of `ext_clk`, and 2'b10 uses falling edges of `ext_clk`. `ext_clk` and `meas_in` each pass through a two-stage synchronizer.
- R7: At completion the count is copied into `readback`. `readback` then holds until the next completion, and reset clears it to 0.
- R8: `done` goes high at completion and stays high until the next trigger. Only one measurement is made per trigger, and reset clears `done`.
- R9: At completion `irq` pulses high for exactly one cycle if `irq_en` is 1, and stays low otherwise.
- R10: A count enable arriving when the counter is at all ones leaves the counter at all ones and sets `overflow`. The saturated value is what `readback` reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_period | input | 1 | 0 measures pulse width, 1 measures period |
| in_pol | input | 2 | Active-level select for meas_in |
| clk_sel | input | 2 | Count enable source select |
| tick | input | 1 | Synchronous internal count enable |
| ext_clk | input | 1 | Asynchronous external count clock |
| meas_in | input | 1 | Asynchronous signal being measured |
| trigger | input | 1 | Clears the counter and arms a measurement |
| irq_en | input | 1 | Enables the completion interrupt pulse |
| readback | output | CNT_W | Latched measurement result |
| done | output | 1 | Measurement complete flag |
| overflow | output | 1 | Counter saturated during this measurement |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Some properties hold on every cycle and are checked that way:
- `irq` never appears without `done` and never lasts two cycles.
- `readback` only moves at completion.
- `done` stays low while a measurement is armed or running.
- A trigger always leaves a cleared, armed state.
- A saturated counter never wraps.

The actual count values need the bench's scenarios, because they depend on the input waveform. These values include:
- widths and periods under both polarities;
- gated ticks and external clock edges of either direction;
- the ignored in-progress interval;
- a restart in mid-measurement;
- a disabled polarity setting.

// File: rtl/meter_pkg.sv
// Shared encodings for the interval meter.
// Assumes: field codes are fixed by the requirements.
package meter_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } meter_state_e;

    localparam logic [1:0] POL_ACT_LOW  = 2'b01;
    localparam logic [1:0] POL_ACT_HIGH = 2'b10;
    localparam logic [1:0] SRC_EXT_RISE = 2'b01;
    localparam logic [1:0] SRC_EXT_FALL = 2'b10;
endpackage

// File: rtl/meter_sync.sv
// Multi-stage synchronizer for asynchronous single-bit inputs.
// Assumes: each bit is independent; no bus coherency is implied.
module meter_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/meter_sat_counter.sv
// Saturating up counter with a priority clear.
// Assumes: clr wins over inc; sat_evt flags an increment refused at the top.
module meter_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         sat_evt
);
    localparam logic [W-1:0] TOP = '1;

    assign sat_evt = inc && !clr && (cnt == TOP);

    // Clear, step, or hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (clr)                  cnt <= '0;
        else if (inc && (cnt != TOP))  cnt <= cnt + 1'b1;
    end

    // R10: saturated counter never wraps
    a_r10_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && inc && !clr) |=> (cnt == TOP));
    // R4: clear leaves zero
    a_r4_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/interval_meter.sv
// Pulse width / period meter: one counter, trigger-armed, single shot.
// Assumes: tick is synchronous to clk; meas_in and ext_clk are asynchronous.
module interval_meter
    import meter_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_period,
    input  logic [1:0]       in_pol,
    input  logic [1:0]       clk_sel,
    input  logic             tick,
    input  logic             ext_clk,
    input  logic             meas_in,
    input  logic             trigger,
    input  logic             irq_en,
    output logic [CNT_W-1:0] readback,
    output logic             done,
    output logic             overflow,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    meter_state_e     state;
    logic             meas_s, ext_s, ext_q, act, act_q;
    logic             pol_ok, start_edge, stop_edge, cnt_en, finish, inc;
    logic [CNT_W-1:0] cnt_val;
    logic             sat_evt;

    meter_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ext_clk, meas_in}), .q({ext_s, meas_s})
    );

    // Decode the active level and find interval edges.
    assign pol_ok     = (in_pol == POL_ACT_LOW) || (in_pol == POL_ACT_HIGH);
    assign act        = pol_ok && (meas_s == (in_pol == POL_ACT_HIGH));
    assign start_edge = act && !act_q;
    assign stop_edge  = !act && act_q;

    // Pick the count enable source.
    always_comb begin
        case (clk_sel)
            SRC_EXT_RISE: cnt_en = ext_s && !ext_q;
            SRC_EXT_FALL: cnt_en = !ext_s && ext_q;
            default:      cnt_en = tick;
        endcase
    end

    assign finish = (state == ST_COUNT) && (mode_period ? start_edge : stop_edge);
    assign inc    = cnt_en && (((state == ST_ARMED) && start_edge) ||
                               ((state == ST_COUNT) && !finish));

    // Remember previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            ext_q <= 1'b0;
        end else begin
            act_q <= act;
            ext_q <= ext_s;
        end
    end

    meter_sat_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(trigger), .inc(inc),
        .cnt(cnt_val), .sat_evt(sat_evt)
    );

    // Sequence arm, count and completion; latch results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            readback <= '0;
            done     <= 1'b0;
            overflow <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (trigger) begin
                state    <= ST_ARMED;
                done     <= 1'b0;
                overflow <= 1'b0;
            end else begin
                if (sat_evt) overflow <= 1'b1;
                case (state)
                    ST_ARMED: if (start_edge) state <= ST_COUNT;
                    ST_COUNT: if (finish) begin
                        readback <= cnt_val;
                        done     <= 1'b1;
                        irq      <= irq_en;
                        state    <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: interrupt only alongside done, never two cycles long
    a_r9_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R7: result register moves only at completion
    a_r7_rb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(readback));
    // R8: done stays low while armed or counting
    a_r8_done_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !done);
    // R4: trigger leaves a cleared, armed state
    a_r4_trig_arms: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> (state == ST_ARMED && !done && !overflow));
    // R10: overflow implies a saturated counter
    a_r10_ovf_sat: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (cnt_val == CNT_TOP));
endmodule

// File: tb/interval_meter_test.sv
module interval_meter_test;
    localparam int W   = 8;
    localparam int TOP = (1 << W) - 1;

    logic clk = 0;
    logic rst_n = 0, mode_period = 0, ext_clk = 0, meas_in = 0;
    logic trigger = 0, irq_en = 1, tick = 1;
    logic [1:0] in_pol = 2'b10, clk_sel = 2'b00;
    logic [W-1:0] readback;
    logic done, overflow, irq;

    int checks = 0, fails = 0, cyc = 0, irq_total = 0;
    int tick_mode = 1;
    bit ext_run = 0;
    int ext_ph = 0;
    logic act_lvl = 1;

    // behavioural reference state
    int m_rb = 0, m_cnt = 0, m_st = 0;
    bit m_done = 0, m_ovf = 0, m_irq = 0;
    bit md1 = 0, md2 = 0, ed1 = 0, ed2 = 0, ed3 = 0, mact = 0;
    bit v_ok, v_act, v_start, v_stop, v_tk, v_fin;

    interval_meter #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_period(mode_period), .in_pol(in_pol),
        .clk_sel(clk_sel), .tick(tick), .ext_clk(ext_clk), .meas_in(meas_in),
        .trigger(trigger), .irq_en(irq_en), .readback(readback), .done(done),
        .overflow(overflow), .irq(irq)
    );

    always #4 clk = ~clk;

    // tick and external clock generators
    always @(negedge clk) begin
        case (tick_mode)
            0: tick <= 1'b0;
            1: tick <= 1'b1;
            default: tick <= ~tick;
        endcase
        if (ext_run) begin
            ext_ph = ext_ph + 1;
            if (ext_ph == 2) begin ext_clk <= ~ext_clk; ext_ph = 0; end
        end
    end

    // reference model: state is kept in integers, updated at each edge
    always @(posedge clk) begin
        v_ok    = (in_pol == 2'b01) || (in_pol == 2'b10);
        v_act   = v_ok && (md2 == (in_pol == 2'b10));
        v_start = v_act && !mact;
        v_stop  = !v_act && mact;
        if (clk_sel == 2'b01)      v_tk = ed2 && !ed3;
        else if (clk_sel == 2'b10) v_tk = !ed2 && ed3;
        else                       v_tk = tick;
        if (!rst_n) begin
            m_rb = 0; m_cnt = 0; m_st = 0; m_done = 0; m_ovf = 0; m_irq = 0;
            mact = 0; md1 = 0; md2 = 0; ed1 = 0; ed2 = 0; ed3 = 0;
        end else begin
            m_irq = 0;
            if (trigger) begin
                m_st = 1; m_cnt = 0; m_done = 0; m_ovf = 0;
            end else if (m_st == 1) begin
                if (v_start) begin m_st = 2; if (v_tk) m_cnt = 1; end
            end else if (m_st == 2) begin
                v_fin = mode_period ? v_start : v_stop;
                if (v_fin) begin
                    m_rb = m_cnt; m_done = 1; m_irq = irq_en; m_st = 0;
                end else if (v_tk) begin
                    if (m_cnt == TOP) m_ovf = 1; else m_cnt = m_cnt + 1;
                end
            end
            mact = v_act; ed3 = ed2; ed2 = ed1; ed1 = ext_clk; md2 = md1; md1 = meas_in;
        end
    end

    // per-cycle comparison and watchdog
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (irq) irq_total = irq_total + 1;
        if (rst_n) begin
            checks = checks + 1;
            if (readback !== W'(m_rb)) begin fails++; $display("FAIL R7 readback actual=%0d expected=%0d", readback, m_rb); end
            else if (done !== m_done) begin fails++; $display("FAIL R8 done actual=%0b expected=%0b", done, m_done); end
            else if (overflow !== m_ovf) begin fails++; $display("FAIL R10 overflow actual=%0b expected=%0b", overflow, m_ovf); end
            else if (irq !== m_irq) begin fails++; $display("FAIL R9 irq actual=%0b expected=%0b", irq, m_irq); end
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire;
        trigger = 1; @(negedge clk); trigger = 0;
    endtask

    task automatic pulse(input int n);
        meas_in = act_lvl; wait_n(n); meas_in = ~act_lvl;
    endtask

    int irq0;
    logic [W-1:0] rb_prev;

    initial begin
        wait_n(3);
        rst_n = 1;
        @(negedge clk);
        chk("R7 reset readback", readback, 0);
        chk("R8 reset done", done, 0);
        chk("R10 reset overflow", overflow, 0);
        chk("R9 reset irq", irq, 0);

        // R2 active-high width
        irq0 = irq_total;
        fire; wait_n(3); pulse(20); wait_n(6);
        chk("R2 width high", readback, 20);
        chk("R8 done after width", done, 1);
        chk("R9 one irq", irq_total - irq0, 1);

        // R1 active-low width
        in_pol = 2'b01; act_lvl = 0; meas_in = 1; wait_n(4);
        fire; wait_n(3); pulse(13); wait_n(6);
        chk("R1 active-low width", readback, 13);

        // R5 interval in progress at trigger is ignored
        in_pol = 2'b10; act_lvl = 1; meas_in = 1; wait_n(5);
        fire; wait_n(4); meas_in = 0; wait_n(4);
        chk("R5 still armed", done, 0);
        pulse(7); wait_n(6);
        chk("R5 next pulse only", readback, 7);

        // R3 period, one measurement per trigger (R8)
        mode_period = 1; irq0 = irq_total;
        fire; wait_n(3);
        for (int k = 0; k < 3; k++) begin pulse(5); wait_n(9); end
        wait_n(4);
        chk("R3 period", readback, 14);
        chk("R8 single shot irq", irq_total - irq0, 1);
        mode_period = 0;

        // R2 gated tick
        tick_mode = 2;
        fire; wait_n(3); pulse(20); wait_n(6);
        chk("R2 gated tick", readback, 10);

        // R6 external rising and falling
        tick_mode = 0; ext_run = 1; clk_sel = 2'b01;
        fire; wait_n(3); pulse(40); wait_n(6);
        chk("R6 ext rising", readback, 10);
        clk_sel = 2'b10;
        fire; wait_n(3); pulse(24); wait_n(6);
        chk("R6 ext falling", readback, 6);
        ext_run = 0; clk_sel = 2'b00; tick_mode = 1; wait_n(2);

        // R1 disabled polarity codes
        rb_prev = readback; irq0 = irq_total;
        for (int p = 0; p < 2; p++) begin
            in_pol = (p == 0) ? 2'b00 : 2'b11;
            fire; wait_n(3); meas_in = 1; wait_n(10); meas_in = 0; wait_n(10); meas_in = 1; wait_n(10); meas_in = 0; wait_n(6);
            chk("R1 disabled no done", done, 0);
            chk("R1 disabled readback kept", readback, rb_prev);
        end
        chk("R1 disabled no irq", irq_total - irq0, 0);
        in_pol = 2'b10; act_lvl = 1;

        // R10 saturation
        fire; wait_n(3); pulse(300); wait_n(6);
        chk("R10 saturated readback", readback, TOP);
        chk("R10 overflow set", overflow, 1);
        fire;
        chk("R4 trigger clears overflow", overflow, 0);
        chk("R4 trigger clears done", done, 0);

        // R9 interrupt disabled
        irq_en = 0; irq0 = irq_total;
        wait_n(3); pulse(9); wait_n(6);
        chk("R9 no irq when disabled", irq_total - irq0, 0);
        chk("R9 result still made", readback, 9);
        irq_en = 1;

        // R4 restart mid-measurement
        fire; wait_n(3); meas_in = 1; wait_n(15);
        fire; wait_n(10); meas_in = 0; wait_n(4);
        chk("R4 restart abandons", done, 0);
        pulse(6); wait_n(6);
        chk("R4 restart result", readback, 6);

        wait_n(4);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule